// File: doc/BRIEF.md
# Outstanding Line Request Tracker

This block sits between a processor port and a cache hierarchy and keeps track of every memory request that is still in flight. It holds two small fully associative tables, one for read-class requests and one for write-class requests, each keyed by cache-line address. Each new request is looked up in both tables in the cycle it is offered. It is either taken into the table for its class or turned away as aliased because it collides with a pending entry on the same line. Each kind of collision has its own counter.

A completion channel names a table and a line and frees the matching entry. A completion that arrives in the same cycle as a new request is applied before the request is looked up. When the outstanding count reaches its parameterised maximum, the request channel drops ready, so a request is held back and never lost.

A periodic deadlock check runs while anything is outstanding. It looks for an entry whose age has reached a threshold and raises a sticky flag that reports the line and request type of the first such entry.

Top module: `line_req_tracker`

## Requirements
- R1: The 4-bit request type code picks the table. Codes 3 (store), 4 (atomic), 5 (store-conditional), 6 (locked read-modify-write read), 7 (locked read-modify-write write) and 8 (flush) are write-class. Every other code (0 load, 1 instruction fetch, 2 load-linked, 9 prefetch, 10 to 15) is read-class.
- R2: A write-class request to a line with a pending read is aliased (req_alias high, req_accept low in the offer cycle), is not stored, and adds one to cnt_store_on_load.
- R3: A write-class request to a line with a pending write and no pending read is aliased and adds one to cnt_store_on_store.
- R4: A read-class request to a line with a pending write is aliased and adds one to cnt_load_on_store.
- R5: A read-class request to a line with a pending read and no pending write is aliased and adds one to cnt_load_on_load.
- R6: An accepted request raises `outstanding` by one after the clock edge. A completion frees only a matching entry in the table that cpl_is_write selects (1 = write table) and lowers `outstanding` by one. `outstanding` always equals the number of valid entries in both tables, and is 0 after reset.
- R7: While `outstanding` equals MAX_OUT, req_ready is low and an offered request is neither accepted nor aliased. It is accepted once ready returns.
- R8: A completion in the same cycle as a request to the same line frees the entry first, so the request is judged against the table without that entry.
- R9: Every THRESH cycles while at least one request is outstanding, the deadlock check flags an entry whose age is at least THRESH. It raises `deadlock`, which stays high until reset, and reports the line and type of the first flagged entry, read entries scanned first.
- R10: Requests that complete within a few cycles never raise `deadlock`, however long such traffic runs.
- R11: Requests to different lines never alias, whatever their class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Tracker can take a request (outstanding below MAX_OUT) |
| req_line | input | ADDR_W | Cache-line address of the request |
| req_kind | input | 4 | Request type code (see R1) |
| req_accept | output | 1 | Request taken into a table this cycle |
| req_alias | output | 1 | Request rejected as aliased this cycle |
| cpl_valid | input | 1 | Completion present |
| cpl_is_write | input | 1 | Completion targets the write table (1) or the read table (0) |
| cpl_line | input | ADDR_W | Line address being completed |
| outstanding | output | $clog2(MAX_OUT+1) | Number of pending requests |
| cnt_store_on_load | output | CNT_W | Write-class requests aliased on a pending read |
| cnt_store_on_store | output | CNT_W | Write-class requests aliased on a pending write |
| cnt_load_on_store | output | CNT_W | Read-class requests aliased on a pending write |
| cnt_load_on_load | output | CNT_W | Read-class requests aliased on a pending read |
| deadlock | output | 1 | Sticky flag: an entry aged past the threshold |
| deadlock_line | output | ADDR_W | Line of the first flagged entry |
| deadlock_kind | output | 4 | Request type of the first flagged entry |

## Verification
Two functions can meet in one cycle. A completion can free a line in the same cycle a new request for that line is looked up. A completion can also arrive in the cycle the table is full and ready is still low. The bench offers a store to a line whose read completes in that very cycle and expects acceptance with no alias and an unchanged conflict count. It also holds a request against a full tracker while an entry completes and expects acceptance only in the following cycle. The deadlock check is judged against short request and completion bursts that cross many check intervals without a flag, and then against one request left pending long enough to be reported by line and type.

// File: rtl/lrt_pkg.sv
package lrt_pkg;
   localparam int KIND_W = 4;
   localparam int NUM_CF = 4;

   typedef enum logic [KIND_W-1:0] {
      RQ_LOAD        = 4'd0,
      RQ_IFETCH      = 4'd1,
      RQ_LOAD_LINKED = 4'd2,
      RQ_STORE       = 4'd3,
      RQ_ATOMIC      = 4'd4,
      RQ_STORE_COND  = 4'd5,
      RQ_LOCK_RD     = 4'd6,
      RQ_LOCK_WR     = 4'd7,
      RQ_FLUSH       = 4'd8,
      RQ_PREFETCH    = 4'd9
   } rq_kind_e;

   typedef enum logic [1:0] {
      CF_ST_LD = 2'd0,
      CF_ST_ST = 2'd1,
      CF_LD_ST = 2'd2,
      CF_LD_LD = 2'd3
   } conflict_e;

   // write-class membership; undefined codes fall to the read class
   function automatic logic is_write_class(input logic [KIND_W-1:0] k);
      case (k)
         RQ_STORE, RQ_ATOMIC, RQ_STORE_COND,
         RQ_LOCK_RD, RQ_LOCK_WR, RQ_FLUSH: return 1'b1;
         default:                          return 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/lrt_cam.sv
module lrt_cam #(
   parameter int DEPTH  = 4,
   parameter int ADDR_W = 32,
   parameter int KIND_W = 4,
   parameter int CYC_W  = 16
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [ADDR_W-1:0]                 look_line,
   output logic                              look_hit,
   input  logic                              free_en,
   input  logic [ADDR_W-1:0]                 free_line,
   output logic                              free_hit,
   input  logic                              ins_en,
   input  logic [KIND_W-1:0]                 ins_kind,
   input  logic [CYC_W-1:0]                  ins_cyc,
   output logic                              ins_room,
   output logic [DEPTH-1:0]                  ent_valid,
   output logic [DEPTH-1:0][ADDR_W-1:0]      ent_line,
   output logic [DEPTH-1:0][KIND_W-1:0]      ent_kind,
   output logic [DEPTH-1:0][CYC_W-1:0]       ent_cyc
);
   logic [DEPTH-1:0] free_mask;
   logic [DEPTH-1:0] live;
   logic [DEPTH-1:0] look_mask;
   logic [DEPTH-1:0] ins_sel;

   // per-entry comparators; frees are applied before the lookup
   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign free_mask[i] = free_en & ent_valid[i] & (ent_line[i] == free_line);
      assign live[i]      = ent_valid[i] & ~free_mask[i];
      assign look_mask[i] = live[i] & (ent_line[i] == look_line);
   end

   assign look_hit = |look_mask;
   assign free_hit = |free_mask;

   // lowest free slot after this cycle's free
   always_comb begin
      ins_sel  = '0;
      ins_room = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!live[i] && !ins_room) begin
            ins_sel[i] = 1'b1;
            ins_room   = 1'b1;
         end
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_valid[i] <= 1'b0;
            ent_line[i]  <= '0;
            ent_kind[i]  <= '0;
            ent_cyc[i]   <= '0;
         end else if (ins_en && ins_sel[i]) begin
            ent_valid[i] <= 1'b1;
            ent_line[i]  <= look_line;
            ent_kind[i]  <= ins_kind;
            ent_cyc[i]   <= ins_cyc;
         end else begin
            ent_valid[i] <= live[i];
         end
      end
   end
endmodule

// File: rtl/lrt_sat_cnt.sv
module lrt_sat_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] value
);
   always_ff @(posedge clk) begin
      if (!rst_n)                  value <= '0;
      else if (inc && value != '1) value <= value + W'(1);
   end
endmodule

// File: rtl/lrt_watchdog.sv
module lrt_watchdog #(
   parameter int ENT    = 8,
   parameter int ADDR_W = 32,
   parameter int KIND_W = 4,
   parameter int CYC_W  = 16,
   parameter int THRESH = 64
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         any_out,
   input  logic [CYC_W-1:0]             cyc_now,
   input  logic [ENT-1:0]               ent_valid,
   input  logic [ENT-1:0][ADDR_W-1:0]   ent_line,
   input  logic [ENT-1:0][KIND_W-1:0]   ent_kind,
   input  logic [ENT-1:0][CYC_W-1:0]    ent_cyc,
   output logic                         chk_fire,
   output logic                         dl_flag,
   output logic [ADDR_W-1:0]            dl_line,
   output logic [KIND_W-1:0]            dl_kind
);
   localparam int TW = (THRESH > 2) ? $clog2(THRESH) : 1;

   logic                        armed;
   logic [TW-1:0]               timer;
   logic [ENT-1:0][CYC_W-1:0]   age;
   logic                        scan_hit;
   logic [ADDR_W-1:0]           scan_line;
   logic [KIND_W-1:0]           scan_kind;

   for (genvar i = 0; i < ENT; i++) begin : g_age
      assign age[i] = cyc_now - ent_cyc[i];
   end

   always_comb begin
      scan_hit  = 1'b0;
      scan_line = '0;
      scan_kind = '0;
      for (int i = 0; i < ENT; i++) begin
         if (ent_valid[i] && age[i] >= CYC_W'(THRESH) && !scan_hit) begin
            scan_hit  = 1'b1;
            scan_line = ent_line[i];
            scan_kind = ent_kind[i];
         end
      end
   end

   assign chk_fire = armed && (timer == '0) && any_out;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         timer   <= '0;
         dl_flag <= 1'b0;
         dl_line <= '0;
         dl_kind <= '0;
      end else begin
         if (!any_out) begin
            armed <= 1'b0;
         end else if (!armed) begin
            armed <= 1'b1;
            timer <= TW'(THRESH - 1);
         end else if (timer == '0) begin
            timer <= TW'(THRESH - 1);
         end else begin
            timer <= timer - TW'(1);
         end
         if (chk_fire && scan_hit && !dl_flag) begin
            dl_flag <= 1'b1;
            dl_line <= scan_line;
            dl_kind <= scan_kind;
         end
      end
   end
endmodule

// File: rtl/line_req_tracker.sv
module line_req_tracker
   import lrt_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int MAX_OUT = 4,
   parameter int CNT_W   = 16,
   parameter int THRESH  = 64,
   parameter int CYC_W   = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   output logic                          req_ready,
   input  logic [ADDR_W-1:0]             req_line,
   input  logic [3:0]                    req_kind,
   output logic                          req_accept,
   output logic                          req_alias,
   input  logic                          cpl_valid,
   input  logic                          cpl_is_write,
   input  logic [ADDR_W-1:0]             cpl_line,
   output logic [$clog2(MAX_OUT+1)-1:0]  outstanding,
   output logic [CNT_W-1:0]              cnt_store_on_load,
   output logic [CNT_W-1:0]              cnt_store_on_store,
   output logic [CNT_W-1:0]              cnt_load_on_store,
   output logic [CNT_W-1:0]              cnt_load_on_load,
   output logic                          deadlock,
   output logic [ADDR_W-1:0]             deadlock_line,
   output logic [3:0]                    deadlock_kind
);
   localparam int DEPTH = MAX_OUT;
   localparam int OCC_W = $clog2(MAX_OUT + 1);
   localparam int ENT   = 2 * DEPTH;

   if (MAX_OUT < 1)                     begin : g_bad_max   $error("MAX_OUT must be positive"); end
   if (THRESH < 2)                      begin : g_bad_thr   $error("THRESH must be at least 2"); end
   if (THRESH >= (1 << (CYC_W - 1)))    begin : g_bad_cyc   $error("CYC_W too narrow for THRESH"); end
   if (CNT_W < 1)                       begin : g_bad_cnt   $error("CNT_W must be positive"); end

   logic [CYC_W-1:0]                 cyc_q;
   logic [OCC_W-1:0]                 occ_q;
   logic                             req_is_wr, fire, room;
   logic                             rd_hit, wr_hit, rd_free_hit, wr_free_hit;
   logic                             rd_room, wr_room;
   logic [NUM_CF-1:0]                cf;
   logic [NUM_CF-1:0][CNT_W-1:0]     cf_cnt;
   logic                             wd_fire;

   logic [DEPTH-1:0]                 rd_valid, wr_valid;
   logic [DEPTH-1:0][ADDR_W-1:0]     rd_line, wr_line;
   logic [DEPTH-1:0][KIND_W-1:0]     rd_kind, wr_kind;
   logic [DEPTH-1:0][CYC_W-1:0]      rd_cyc, wr_cyc;

   assign req_is_wr = is_write_class(req_kind);
   assign req_ready = (occ_q < OCC_W'(MAX_OUT));
   assign fire      = req_valid & req_ready;

   // conflict classification; the opposite table is checked first
   assign cf[CF_ST_LD] = fire &  req_is_wr & rd_hit;
   assign cf[CF_ST_ST] = fire &  req_is_wr & ~rd_hit & wr_hit;
   assign cf[CF_LD_ST] = fire & ~req_is_wr & wr_hit;
   assign cf[CF_LD_LD] = fire & ~req_is_wr & ~wr_hit & rd_hit;

   assign req_alias  = |cf;
   assign room       = req_is_wr ? wr_room : rd_room;
   assign req_accept = fire & ~req_alias & room;

   lrt_cam #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .KIND_W(KIND_W), .CYC_W(CYC_W)) u_rd_tab (
      .clk       (clk),
      .rst_n     (rst_n),
      .look_line (req_line),
      .look_hit  (rd_hit),
      .free_en   (cpl_valid & ~cpl_is_write),
      .free_line (cpl_line),
      .free_hit  (rd_free_hit),
      .ins_en    (req_accept & ~req_is_wr),
      .ins_kind  (req_kind),
      .ins_cyc   (cyc_q),
      .ins_room  (rd_room),
      .ent_valid (rd_valid),
      .ent_line  (rd_line),
      .ent_kind  (rd_kind),
      .ent_cyc   (rd_cyc)
   );

   lrt_cam #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .KIND_W(KIND_W), .CYC_W(CYC_W)) u_wr_tab (
      .clk       (clk),
      .rst_n     (rst_n),
      .look_line (req_line),
      .look_hit  (wr_hit),
      .free_en   (cpl_valid & cpl_is_write),
      .free_line (cpl_line),
      .free_hit  (wr_free_hit),
      .ins_en    (req_accept & req_is_wr),
      .ins_kind  (req_kind),
      .ins_cyc   (cyc_q),
      .ins_room  (wr_room),
      .ent_valid (wr_valid),
      .ent_line  (wr_line),
      .ent_kind  (wr_kind),
      .ent_cyc   (wr_cyc)
   );

   for (genvar g = 0; g < NUM_CF; g++) begin : g_cf_cnt
      lrt_sat_cnt #(.W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (cf[g]),
         .value (cf_cnt[g])
      );
   end

   assign cnt_store_on_load  = cf_cnt[CF_ST_LD];
   assign cnt_store_on_store = cf_cnt[CF_ST_ST];
   assign cnt_load_on_store  = cf_cnt[CF_LD_ST];
   assign cnt_load_on_load   = cf_cnt[CF_LD_LD];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cyc_q <= '0;
         occ_q <= '0;
      end else begin
         cyc_q <= cyc_q + CYC_W'(1);
         occ_q <= occ_q + OCC_W'(req_accept) - OCC_W'(rd_free_hit | wr_free_hit);
      end
   end

   assign outstanding = occ_q;

   lrt_watchdog #(.ENT(ENT), .ADDR_W(ADDR_W), .KIND_W(KIND_W), .CYC_W(CYC_W), .THRESH(THRESH)) u_wd (
      .clk       (clk),
      .rst_n     (rst_n),
      .any_out   (occ_q != '0),
      .cyc_now   (cyc_q),
      .ent_valid ({wr_valid, rd_valid}),
      .ent_line  ({wr_line, rd_line}),
      .ent_kind  ({wr_kind, rd_kind}),
      .ent_cyc   ({wr_cyc, rd_cyc}),
      .chk_fire  (wd_fire),
      .dl_flag   (deadlock),
      .dl_line   (deadlock_line),
      .dl_kind   (deadlock_kind)
   );
endmodule

// File: rtl/line_req_tracker_chk.sv
module line_req_tracker_chk #(
   parameter int MAX_OUT = 4,
   parameter int DEPTH   = 4,
   parameter int OCC_W   = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             req_accept,
   input logic             req_alias,
   input logic             cpl_valid,
   input logic [OCC_W-1:0] outstanding,
   input logic [DEPTH-1:0] rd_valid,
   input logic [DEPTH-1:0] wr_valid,
   input logic             deadlock
);
   // R6
   occ_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(outstanding) == $countones(rd_valid) + $countones(wr_valid));

   // R6
   occ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_accept && !cpl_valid) |=> (outstanding == $past(outstanding) + OCC_W'(1)));

   // R7
   full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(outstanding) == MAX_OUT) |-> !req_ready);

   // R7
   accept_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_accept || req_alias) |-> (req_valid && req_ready));

   // R2
   alias_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_accept && req_alias));

   // R9
   deadlock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deadlock |=> deadlock);

   // R9
   deadlock_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(deadlock) |-> ($past(outstanding) != '0));
endmodule

bind line_req_tracker line_req_tracker_chk #(
   .MAX_OUT (MAX_OUT),
   .DEPTH   (DEPTH),
   .OCC_W   (OCC_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .req_accept  (req_accept),
   .req_alias   (req_alias),
   .cpl_valid   (cpl_valid),
   .outstanding (outstanding),
   .rd_valid    (rd_valid),
   .wr_valid    (wr_valid),
   .deadlock    (deadlock)
);

// File: tb/line_req_tracker_bench.sv
module line_req_tracker_bench;
   localparam int ADDR_W  = 32;
   localparam int MAX_OUT = 4;
   localparam int CNT_W   = 16;
   localparam int THRESH  = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [ADDR_W-1:0] req_line = '0;
   logic [3:0]        req_kind = '0;
   logic              req_accept, req_alias;
   logic              cpl_valid = 1'b0;
   logic              cpl_is_write = 1'b0;
   logic [ADDR_W-1:0] cpl_line = '0;
   logic [2:0]        outstanding;
   logic [CNT_W-1:0]  c_sl, c_ss, c_ls, c_ll;
   logic              deadlock;
   logic [ADDR_W-1:0] deadlock_line;
   logic [3:0]        deadlock_kind;

   int checks = 0;
   int errors = 0;
   int e_sl = 0, e_ss = 0, e_ls = 0, e_ll = 0;
   logic s_acc, s_ali, s_rdy;
   bit done = 0;

   always #2.5 clk = ~clk;

   line_req_tracker #(.ADDR_W(ADDR_W), .MAX_OUT(MAX_OUT), .CNT_W(CNT_W), .THRESH(THRESH)) u_line_req_tracker (
      .clk, .rst_n, .req_valid, .req_ready, .req_line, .req_kind, .req_accept, .req_alias,
      .cpl_valid, .cpl_is_write, .cpl_line, .outstanding,
      .cnt_store_on_load(c_sl), .cnt_store_on_store(c_ss),
      .cnt_load_on_store(c_ls), .cnt_load_on_load(c_ll),
      .deadlock, .deadlock_line, .deadlock_kind
   );

   function automatic bit wr_cls(input int k);
      return (k >= 3 && k <= 8);
   endfunction

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // one clock: drive at negedge, sample responses before the edge, release after
   task automatic step(input logic rv, input logic [ADDR_W-1:0] rl, input logic [3:0] rk,
                       input logic cv, input logic cw, input logic [ADDR_W-1:0] cl);
      @(negedge clk);
      req_valid = rv; req_line = rl; req_kind = rk;
      cpl_valid = cv; cpl_is_write = cw; cpl_line = cl;
      #1;
      s_acc = req_accept; s_ali = req_alias; s_rdy = req_ready;
      @(posedge clk);
      #1;
      req_valid = 1'b0; cpl_valid = 1'b0;
   endtask

   task automatic req(input logic [ADDR_W-1:0] l, input logic [3:0] k);
      step(1'b1, l, k, 1'b0, 1'b0, '0);
   endtask

   task automatic cpl(input logic [ADDR_W-1:0] l, input logic w);
      step(1'b0, '0, 4'd0, 1'b1, w, l);
   endtask

   task automatic chk_cnts(input string r);
      chk(r, "cnt_store_on_load", 64'(c_sl), 64'(e_sl));
      chk(r, "cnt_store_on_store", 64'(c_ss), 64'(e_ss));
      chk(r, "cnt_load_on_store", 64'(c_ls), 64'(e_ls));
      chk(r, "cnt_load_on_load", 64'(c_ll), 64'(e_ll));
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R6", "outstanding after reset", 64'(outstanding), 0);
      chk("R7", "ready after reset", 64'(req_ready), 1);
      chk("R9", "deadlock after reset", 64'(deadlock), 0);
      chk_cnts("R2");
   endtask

   task automatic t_classes();   // R1
      for (int k = 0; k < 16; k++) begin
         logic [ADDR_W-1:0] l;
         l = 32'h100 + 32'(k);
         req(l, 4'(k));
         chk("R1", "first request accepted", 64'(s_acc), 1);
         req(l, 4'd0);
         chk("R1", "load behind typed request aliases", 64'(s_ali), 1);
         if (wr_cls(k)) e_ls++; else e_ll++;
         chk_cnts("R1");
         cpl(l, wr_cls(k));
         chk("R1", "completion to class table frees", 64'(outstanding), 0);
      end
   endtask

   task automatic t_store_on_load();   // R2
      req(32'h200, 4'd0);
      req(32'h200, 4'd3);
      chk("R2", "store on pending load alias", 64'(s_ali), 1);
      chk("R2", "store on pending load not accepted", 64'(s_acc), 0);
      e_sl++;
      chk_cnts("R2");
      chk("R2", "alias not stored", 64'(outstanding), 1);
      cpl(32'h200, 1'b0);
   endtask

   task automatic t_store_on_store();   // R3
      req(32'h300, 4'd3);
      req(32'h300, 4'd8);
      chk("R3", "flush on pending store alias", 64'(s_ali), 1);
      e_ss++;
      chk_cnts("R3");
      cpl(32'h300, 1'b1);
      chk("R3", "drained", 64'(outstanding), 0);
   endtask

   task automatic t_load_on_store();   // R4
      req(32'h400, 4'd4);
      req(32'h400, 4'd1);
      chk("R4", "fetch on pending atomic alias", 64'(s_ali), 1);
      e_ls++;
      chk_cnts("R4");
      cpl(32'h400, 1'b1);
   endtask

   task automatic t_load_on_load();   // R5
      req(32'h500, 4'd0);
      req(32'h500, 4'd9);
      chk("R5", "prefetch on pending load alias", 64'(s_ali), 1);
      e_ll++;
      chk_cnts("R5");
      cpl(32'h500, 1'b0);
   endtask

   task automatic t_distinct();   // R11, R6
      req(32'h600, 4'd0);
      chk("R11", "load accepted", 64'(s_acc), 1);
      req(32'h601, 4'd3);
      chk("R11", "store to other line accepted", 64'(s_acc), 1);
      chk("R6", "two outstanding", 64'(outstanding), 2);
      cpl(32'h600, 1'b1);
      chk("R6", "completion to wrong table frees nothing", 64'(outstanding), 2);
      cpl(32'h600, 1'b0);
      cpl(32'h601, 1'b1);
      chk("R6", "all freed", 64'(outstanding), 0);
      chk_cnts("R11");
   endtask

   task automatic t_full();   // R7
      for (int i = 0; i < MAX_OUT; i++) req(32'h700 + 32'(i), 4'd0);
      chk("R7", "count at max", 64'(outstanding), MAX_OUT);
      req(32'h704, 4'd0);
      chk("R7", "ready low when full", 64'(s_rdy), 0);
      chk("R7", "no accept when full", 64'(s_acc), 0);
      chk("R7", "no alias when full", 64'(s_ali), 0);
      step(1'b1, 32'h704, 4'd0, 1'b1, 1'b0, 32'h700);
      chk("R7", "still stalled in completion cycle", 64'(s_acc), 0);
      req(32'h704, 4'd0);
      chk("R7", "accepted once ready returns", 64'(s_acc), 1);
      chk("R7", "count back at max", 64'(outstanding), MAX_OUT);
      for (int i = 1; i <= MAX_OUT; i++) cpl(32'h700 + 32'(i), 1'b0);
      chk("R7", "drained", 64'(outstanding), 0);
      chk_cnts("R7");
   endtask

   task automatic t_same_cycle();   // R8
      req(32'h800, 4'd0);
      step(1'b1, 32'h800, 4'd3, 1'b1, 1'b0, 32'h800);
      chk("R8", "store accepted as read frees", 64'(s_acc), 1);
      chk("R8", "no alias", 64'(s_ali), 0);
      chk("R8", "one outstanding", 64'(outstanding), 1);
      chk_cnts("R8");
      cpl(32'h800, 1'b1);
      chk("R8", "drained", 64'(outstanding), 0);
   endtask

   task automatic t_wd_quiet();   // R10
      for (int i = 0; i < 3 * THRESH; i++) begin
         req(32'hA00 + 32'(i % 8), 4'(i % 10));
         cpl(32'hA00 + 32'(i % 8), wr_cls(i % 10));
      end
      chk("R10", "no deadlock under short traffic", 64'(deadlock), 0);
      chk("R10", "drained", 64'(outstanding), 0);
   endtask

   task automatic t_wd_flag();   // R9
      repeat (2 * THRESH) @(negedge clk);
      chk("R9", "idle tracker raises nothing", 64'(deadlock), 0);
      req(32'h9A, 4'd6);
      repeat (THRESH / 2) @(negedge clk);
      chk("R9", "young entry not flagged", 64'(deadlock), 0);
      repeat (3 * THRESH) @(negedge clk);
      chk("R9", "old entry flagged", 64'(deadlock), 1);
      chk("R9", "flagged line", 64'(deadlock_line), 64'h9A);
      chk("R9", "flagged kind", 64'(deadlock_kind), 6);
      cpl(32'h9A, 1'b1);
      repeat (4) @(negedge clk);
      chk("R9", "flag sticky after completion", 64'(deadlock), 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_classes();
      t_store_on_load();
      t_store_on_store();
      t_load_on_store();
      t_load_on_load();
      t_distinct();
      t_full();
      t_same_cycle();
      t_wd_quiet();
      t_wd_flag();
      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog run did not finish actual=%0d expected=done", cyc);
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule